// File: doc/BRIEF.md
# Period-Register PWM Generator

The block drives one pulse-width-modulated output from a free-running timebase. The timebase is built from an 8-bit period register and two extra low-order sub-tick bits, which makes a 10-bit count. It climbs from zero to the period value, with both sub-tick bits set, and then wraps. The 10-bit duty value is compared against this extended count. A wide period gives the full duty resolution. A narrow period leaves fewer usable duty steps, because each step is one count of the same timebase. A selectable prescaler divides the clock ahead of the timebase.

Software sets the period, the duty value and the prescale ratio through a small register-write port. The duty value sits in a write buffer and is only copied into the live compare register when a new period starts, so a change never produces a truncated or stretched pulse. A one-cycle rollover strobe marks every wrap of the timebase.

Top module: `pwm_period_gen`

## Requirements
- R1: While rst_ni is low, pwm_o and rollover_o are low. Reset clears the period to 0, the duty buffer to 0 and the prescale select to 0 (divide by 1).
- R2: With the prescaler at divide by 1, rollover_o pulses every 4*(P+1) clock cycles, where P is the period register value.
- R3: Prescale select code 0 divides the clock by 1, code 1 by 4, and codes 2 and 3 by 16. The period becomes 4*(P+1)*ratio clock cycles.
- R4: For 0 < D < 4*(P+1), pwm_o goes high in the cycle rollover_o is high and stays high for D*ratio cycles of each period. D is the live duty value.
- R5: For D >= 4*(P+1), pwm_o is high for the whole period.
- R6: For D = 0, pwm_o is low for the whole period.
- R7: A duty write takes effect only at the next period start. The period in progress completes with the old duty value.
- R8: rollover_o is a single-cycle pulse and occurs exactly once per period.
- R9: While en_i is low, pwm_o and rollover_o stay low and the prescaler and timebase are held. After en_i rises, the first rollover_o pulse starts a fresh period one prescaled tick later, that is `ratio` cycles after en_i is first sampled high.
- R10: Writes occur only when wr_en_i is high. Address 0 holds the period (wr_data_i[7:0]), address 1 the duty (wr_data_i[9:0]) and address 2 the prescale select (wr_data_i[1:0]). Address 3 and any cycle with wr_en_i low change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable for the prescaler and timebase |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 period, 1 duty, 2 prescale |
| wr_data_i | input | 10 | Write data |
| pwm_o | output | 1 | PWM output level |
| rollover_o | output | 1 | One-cycle strobe when the timebase wraps to zero |

## Verification
The assertions check the following on every cycle:
- the strobe never lasts two cycles, and the count is zero whenever the strobe is high;
- the output only rises together with the strobe, and stays low at the strobe when the duty value is zero;
- the live duty value never changes between period starts;
- the output and strobe are quiet after a disabled cycle;
- writes to the unused address leave every register unchanged;
- the prescaler restarts after each tick.

Exact period lengths and high times for each prescale ratio, the full-period and zero-duty boundaries, the deferred duty update and the phase after enable can only be shown by the bench's scenarios.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'd0,
    PS_DIV4   = 2'd1,
    PS_DIV16  = 2'd2,
    PS_DIV16B = 2'd3
  } presc_sel_e;

  typedef enum logic [1:0] {
    REG_PERIOD = 2'd0,
    REG_DUTY   = 2'd1,
    REG_PRESC  = 2'd2,
    REG_NONE   = 2'd3
  } reg_addr_e;

  localparam int unsigned PRE_W = 4;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned PR_W   = 8,
  parameter int unsigned DUTY_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DUTY_W-1:0] wr_data_i,
  output logic [PR_W-1:0]   period_o,
  output logic [DUTY_W-1:0] duty_buf_o,
  output presc_sel_e        presc_o
);

  logic [PR_W-1:0]   period_q;
  logic [DUTY_W-1:0] duty_q;
  presc_sel_e        presc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      duty_q   <= '0;
      presc_q  <= PS_DIV1;
    end else if (wr_en_i) begin
      unique case (reg_addr_e'(wr_addr_i))
        REG_PERIOD: period_q <= wr_data_i[PR_W-1:0];
        REG_DUTY:   duty_q   <= wr_data_i;
        REG_PRESC:  presc_q  <= presc_sel_e'(wr_data_i[1:0]);
        default:    ;
      endcase
    end
  end

  assign period_o   = period_q;
  assign duty_buf_o = duty_q;
  assign presc_o    = presc_q;

  AST_UNUSED_ADDR_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || wr_addr_i == REG_NONE) |=> ($stable(period_q) && $stable(duty_q) && $stable(presc_q))); // R10

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  presc_sel_e sel_i,
  output logic       tick_o
);

  logic [PRE_W-1:0] pre_cnt_q;
  logic [PRE_W-1:0] limit;

  always_comb begin
    unique case (sel_i)
      PS_DIV1: limit = PRE_W'(0);
      PS_DIV4: limit = PRE_W'(3);
      default: limit = PRE_W'(15);
    endcase
  end

  // >= so that a ratio lowered mid-count still ticks at once
  assign tick_o = en_i && (pre_cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_cnt_q <= '0;
    else if (!en_i)   pre_cnt_q <= '0;
    else if (tick_o)  pre_cnt_q <= '0;
    else              pre_cnt_q <= pre_cnt_q + 1'b1;
  end

  AST_PRESC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (pre_cnt_q == '0)); // R3

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned PR_W  = 8,
  parameter int unsigned SUB_W = 2,
  localparam int unsigned CNT_W = PR_W + SUB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [PR_W-1:0]  period_i,
  output logic             wrap_o,
  output logic [CNT_W-1:0] next_cnt_o,
  output logic             roll_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top;
  logic             roll_q;

  assign top        = {period_i, {SUB_W{1'b1}}};
  // >= so that a shrunk period wraps on the next tick
  assign wrap_o     = tick_i && (cnt_q >= top);
  assign next_cnt_o = wrap_o ? '0 : (tick_i ? cnt_q + 1'b1 : cnt_q);

  // parked at all ones while idle: the first tick wraps and opens a period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      roll_q <= 1'b0;
    end else begin
      roll_q <= wrap_o;
      if (!en_i) cnt_q <= '1;
      else       cnt_q <= next_cnt_o;
    end
  end

  assign roll_o = roll_q;

  AST_ROLL_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_q |-> (cnt_q == '0)); // R2
  AST_ROLL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_q |=> !roll_q); // R8

endmodule

// File: rtl/pwm_output.sv
module pwm_output #(
  parameter int unsigned DUTY_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              wrap_i,
  input  logic              roll_i,
  input  logic [DUTY_W-1:0] next_cnt_i,
  input  logic [DUTY_W-1:0] duty_buf_i,
  output logic              pwm_o
);

  logic [DUTY_W-1:0] duty_q;
  logic              pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      pwm_q  <= 1'b0;
    end else if (!en_i) begin
      pwm_q  <= 1'b0;
    end else if (wrap_i) begin
      duty_q <= duty_buf_i;
      pwm_q  <= (duty_buf_i != '0);
    end else if (tick_i && next_cnt_i == duty_q) begin
      pwm_q  <= 1'b0;
    end
  end

  assign pwm_o = pwm_q;

  AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_q) |-> roll_i); // R4
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (roll_i && duty_q == '0) |-> !pwm_q); // R6
  AST_DUTY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !roll_i |-> $stable(duty_q)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pwm_q && !roll_i)); // R9

endmodule

// File: rtl/pwm_period_gen.sv
module pwm_period_gen
  import pwm_pkg::*;
#(
  parameter int unsigned PR_W  = 8,
  parameter int unsigned SUB_W = 2,
  localparam int unsigned DUTY_W = PR_W + SUB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DUTY_W-1:0] wr_data_i,
  output logic              pwm_o,
  output logic              rollover_o
);

  logic [PR_W-1:0]   period;
  logic [DUTY_W-1:0] duty_buf;
  presc_sel_e        presc;
  logic              tick;
  logic              wrap;
  logic              roll;
  logic [DUTY_W-1:0] next_cnt;

  pwm_regs #(.PR_W(PR_W), .DUTY_W(DUTY_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .period_o   (period),
    .duty_buf_o (duty_buf),
    .presc_o    (presc)
  );

  pwm_prescaler u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .sel_i  (presc),
    .tick_o (tick)
  );

  pwm_timebase #(.PR_W(PR_W), .SUB_W(SUB_W)) u_tb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (tick),
    .period_i   (period),
    .wrap_o     (wrap),
    .next_cnt_o (next_cnt),
    .roll_o     (roll)
  );

  pwm_output #(.DUTY_W(DUTY_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (tick),
    .wrap_i     (wrap),
    .roll_i     (roll),
    .next_cnt_i (next_cnt),
    .duty_buf_i (duty_buf),
    .pwm_o      (pwm_o)
  );

  assign rollover_o = roll;

endmodule

// File: tb/tb_pwm_period_gen.sv
module tb_pwm_period_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic       pwm;
  logic       roll;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwm_period_gen dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .pwm_o      (pwm),
    .rollover_o (roll)
  );

  typedef struct packed {
    logic [7:0]  pr;
    logic [9:0]  duty;
    logic [1:0]  ps;
    logic [15:0] hi;
    logic [15:0] per;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'd3,   10'd5,    2'd0, 16'd5,    16'd16},
    '{8'd3,   10'd16,   2'd0, 16'd16,   16'd16},
    '{8'd3,   10'd0,    2'd0, 16'd0,    16'd16},
    '{8'd3,   10'd20,   2'd0, 16'd16,   16'd16},
    '{8'd9,   10'd13,   2'd1, 16'd52,   16'd160},
    '{8'd0,   10'd2,    2'd2, 16'd32,   16'd64},
    '{8'd0,   10'd1,    2'd0, 16'd1,    16'd4},
    '{8'd255, 10'd1023, 2'd0, 16'd1023, 16'd1024},
    '{8'd255, 10'd512,  2'd0, 16'd512,  16'd1024},
    '{8'd7,   10'd31,   2'd0, 16'd31,   16'd32},
    '{8'd1,   10'd3,    2'd3, 16'd48,   16'd128}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_roll();
    do @(negedge clk); while (!roll);
  endtask

  // enter at a strobe negedge; counts one full period
  task automatic measure_from_roll(output int per, output int hi);
    per = 0; hi = 0;
    do begin
      per++;
      if (pwm) hi++;
      @(negedge clk);
    end while (!roll);
  endtask

  task automatic setup(input logic [7:0] pr, input logic [9:0] d, input logic [1:0] ps);
    @(negedge clk); en = 1'b0;
    wr(2'd0, {2'b00, pr});
    wr(2'd1, d);
    wr(2'd2, {8'd0, ps});
    @(negedge clk); en = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got %0d, expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int per, hi, n, bad;
    string tag;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 pwm in reset", int'(pwm), 0);
    check("R1 strobe in reset", int'(roll), 0);
    rst_n = 1'b1; en = 1'b1;
    wait_roll();
    measure_from_roll(per, hi);
    check("R1 default period", per, 4);
    check("R1 default duty", hi, 0);

    // table walk: R2..R6, two periods each to show steady state
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].pr, VECS[i].duty, VECS[i].ps);
      wait_roll();
      measure_from_roll(per, hi);
      measure_from_roll(per, hi);
      tag = (VECS[i].ps != 2'd0) ? "R3 period" : "R2 period";
      check(tag, per, int'(VECS[i].per));
      if (VECS[i].duty == 10'd0)           tag = "R6 high time";
      else if (VECS[i].hi == VECS[i].per)  tag = "R5 high time";
      else                                 tag = "R4 high time";
      check(tag, hi, int'(VECS[i].hi));
    end

    // R8: exactly one strobe cycle per period
    setup(8'd3, 10'd5, 2'd0);
    wait_roll();
    n = 0;
    for (int c = 0; c < 64; c++) begin
      if (roll) n++;
      @(negedge clk);
    end
    check("R8 strobes in 64 cycles", n, 4);

    // R7: duty written mid-period applies only from the next period
    wait_roll();
    per = 0; hi = 0;
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 10'd10;
    do begin
      per++;
      if (pwm) hi++;
      @(negedge clk);
      wr_en = 1'b0;
    end while (!roll);
    check("R7 old duty kept", hi, 5);
    measure_from_roll(per, hi);
    check("R7 new duty applied", hi, 10);

    // R10: writes with wr_en low or to address 3 are ignored
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 2'd0; wr_data = 10'd100;
    @(negedge clk);
    wr(2'd3, 10'd0);
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 2'd1; wr_data = 10'd2;
    wait_roll();
    measure_from_roll(per, hi);
    check("R10 period unchanged", per, 16);
    check("R10 duty unchanged", hi, 10);

    // R9: disabled output quiet, then phase restarts on enable
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    bad = 0;
    for (int c = 0; c < 40; c++) begin
      if (pwm || roll) bad++;
      @(negedge clk);
    end
    check("R9 quiet while disabled", bad, 0);
    wr(2'd2, 10'd1);
    @(negedge clk); en = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!roll);
    check("R9 first strobe after enable", n, 4);
    check("R9 output high at restart", int'(pwm), 1);

    finish_run();
  end

endmodule